// File: doc/BRIEF.md
# Bit-Test-and-Modify Skip Unit

This execution unit handles the logical test instruction group of a 36-bit processor. On each accepted instruction it forms a mask from either an immediate value (the effective address placed in the low half, upper half zero) or a memory operand. It can exchange the two halves of that mask. It ANDs the mask with the accumulator and checks whether the product is zero. From that check and the instruction's skip field it decides whether the following instruction is skipped.

The same instruction can also rewrite the masked accumulator bits. The rewrite leaves them alone, clears them, complements them or sets them. The zero test always uses the accumulator value as it was before the rewrite. The control unit owns the program counter and applies the skip. The register file owns the accumulator and takes the new value when the write enable is high. The result, the write enable and the skip flag appear together one clock after the input strobe.

Opcode layout, most significant bit first: bits [8:6] group code 110, bits [5:4] modify field, bit [3] mask source, bits [2:1] skip field, bit [0] half swap.

Top module: `bit_test_unit`

## Requirements
- R1: A strobe on `op_valid` whose opcode bits [8:6] equal 110 raises `res_valid` for one cycle on the next clock edge. A strobe with any other group code raises neither `res_valid`, `ac_we` nor `skip`.
- R2: When opcode bit 3 is 0, the mask is the effective address in bits [17:0] with bits [35:18] zero. When it is 1, the mask is the memory operand.
- R3: When opcode bit 0 is 1, the mask's bits [35:18] and [17:0] are exchanged before use. When it is 0, the mask is used unchanged.
- R4: Opcode bits [5:4] set `ac_out`: 00 gives the accumulator unchanged, 01 gives AC AND NOT mask, 10 gives AC XOR mask, 11 gives AC OR mask.
- R5: `ac_we` is high together with `res_valid` exactly when bits [5:4] are not 00. It is low in every other cycle.
- R6: Opcode bits [2:1] set `skip`: 00 never, 01 when AC AND mask is zero, 10 always, 11 when AC AND mask is nonzero. `skip` is low whenever `res_valid` is low.
- R7: The zero test uses the accumulator before modification. A set or complement of masked bits does not change the skip decision.
- R8: While `rst_n` is low, `res_valid`, `ac_we`, `skip` and `ac_out` are zero.
- R9: Strobes on consecutive cycles each give their own result one cycle later, with no cycle lost between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction and operands present this cycle |
| opcode | input | 9 | Instruction opcode |
| ac_in | input | 36 | Accumulator value before the instruction |
| mem_in | input | 36 | Memory operand |
| ea | input | 18 | Effective address, used as the immediate mask |
| res_valid | output | 1 | Result present, one cycle after the strobe |
| ac_out | output | 36 | New accumulator value |
| ac_we | output | 1 | Accumulator write enable |
| skip | output | 1 | Skip the next instruction |

## Verification
The bench builds the unit with its default 36-bit word and group code 110. With that build, every mix of modify field, mask source, swap and skip field can be enumerated in 64 opcodes. Each opcode is paired with all-zero and all-one masks and accumulators, and with halves that differ, so a missed swap or a wrong mask source changes the result. Cases where the mask covers only bits that the modification sets show whether the zero test reads the accumulator before or after the rewrite.

// File: rtl/bit_test_unit.sv
module bit_test_unit #(
  parameter int WORD_W = 36,
  parameter logic [2:0] GROUP_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [8:0]        opcode,
  input  logic [WORD_W-1:0] ac_in,
  input  logic [WORD_W-1:0] mem_in,
  input  logic [WORD_W/2-1:0] ea,
  output logic              res_valid,
  output logic [WORD_W-1:0] ac_out,
  output logic              ac_we,
  output logic              skip
);
  localparam int HALF_W = WORD_W / 2;

  logic [1:0] mod_f, skp_f;
  logic hit, zero;
  logic [WORD_W-1:0] raw_mask, mask, nxt_ac;
  logic nxt_skip;

  assign hit   = op_valid && (opcode[8:6] == GROUP_CODE);
  assign mod_f = opcode[5:4];
  assign skp_f = opcode[2:1];

  assign raw_mask = opcode[3] ? mem_in : {{HALF_W{1'b0}}, ea};
  assign mask     = opcode[0] ? {raw_mask[HALF_W-1:0], raw_mask[WORD_W-1:HALF_W]} : raw_mask;
  assign zero     = ((ac_in & mask) == '0);

  always_comb begin
    case (mod_f)
      2'b01:   nxt_ac = ac_in & ~mask;
      2'b10:   nxt_ac = ac_in ^ mask;
      2'b11:   nxt_ac = ac_in | mask;
      default: nxt_ac = ac_in;
    endcase
    case (skp_f)
      2'b01:   nxt_skip = zero;
      2'b10:   nxt_skip = 1'b1;
      2'b11:   nxt_skip = !zero;
      default: nxt_skip = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      ac_we     <= 1'b0;
      skip      <= 1'b0;
      ac_out    <= '0;
    end else begin
      res_valid <= hit;
      ac_we     <= hit && (mod_f != 2'b00);
      skip      <= hit && nxt_skip;
      if (hit) ac_out <= nxt_ac;
    end
  end
endmodule

// File: rtl/bit_test_unit_chk.sv
module bit_test_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [8:0] opcode,
  input logic       res_valid,
  input logic       ac_we,
  input logic       skip
);
  logic grp;
  assign grp = op_valid && (opcode[8:6] == 3'b110);

  assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    grp |=> res_valid);
  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !grp |=> !res_valid);
  assert_we_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ac_we |-> res_valid);
  assert_we_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && opcode[5:4] == 2'b00) |=> !ac_we);
  assert_skip_qual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> res_valid);
  assert_skip_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && opcode[2:1] == 2'b10) |=> skip);
  assert_skip_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grp && opcode[2:1] == 2'b00) |=> !skip);
endmodule

bind bit_test_unit bit_test_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .res_valid(res_valid), .ac_we(ac_we), .skip(skip)
);

// File: tb/bit_test_unit_tb.sv
module bit_test_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 36;
  localparam int H = 18;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [8:0] opcode = '0;
  logic [W-1:0] ac_in = '0, mem_in = '0;
  logic [H-1:0] ea = '0;
  logic res_valid, ac_we, skip;
  logic [W-1:0] ac_out;
  int checks = 0, fails = 0;
  logic [W-1:0] seed = 36'h9A5C3E1F7;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_test_unit u_dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .ac_in(ac_in), .mem_in(mem_in), .ea(ea), .res_valid(res_valid), .ac_out(ac_out),
    .ac_we(ac_we), .skip(skip));

  function automatic logic [W-1:0] nxt_rand(input logic [W-1:0] s);
    logic [W-1:0] x = s;
    x = x ^ (x << 7);
    x = x ^ (x >> 11);
    x = x ^ (x << 3);
    return (x == '0) ? 36'h1 : x;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [8:0] op, input logic [W-1:0] ac,
                         input logic [W-1:0] mem, input logic [H-1:0] e);
    logic [W-1:0] m, prod, exp_ac;
    logic grp, exp_skip, exp_we;
    grp = (op[8:6] == 3'b110);
    m = op[3] ? mem : {{H{1'b0}}, e};             // R2 mask source
    if (op[0]) m = {m[H-1:0], m[W-1:H]};          // R3 swap
    prod = ac & m;                                // R7 original AC
    case (op[5:4])
      2'b00: exp_ac = ac;
      2'b01: exp_ac = ac & ~m;
      2'b10: exp_ac = ac ^ m;
      default: exp_ac = ac | m;
    endcase
    case (op[2:1])
      2'b00: exp_skip = 1'b0;
      2'b01: exp_skip = (prod == '0);
      2'b10: exp_skip = 1'b1;
      default: exp_skip = (prod != '0);
    endcase
    exp_we = grp && (op[5:4] != 2'b00);
    exp_skip = grp && exp_skip;
    @(negedge clk);
    op_valid = 1'b1; opcode = op; ac_in = ac; mem_in = mem; ea = e;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1 res_valid", {35'd0, res_valid}, {35'd0, grp});
    chk("R5 ac_we", {35'd0, ac_we}, {35'd0, exp_we});
    chk("R6/R7 skip", {35'd0, skip}, {35'd0, exp_skip});
    if (grp) chk("R2/R3/R4 ac_out", ac_out, exp_ac);
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2 + 1);
    chk("R8 res_valid", {35'd0, res_valid}, 36'd0);
    chk("R8 ac_we", {35'd0, ac_we}, 36'd0);
    chk("R8 skip", {35'd0, skip}, 36'd0);
    chk("R8 ac_out", ac_out, 36'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_all_combos;
    for (int k = 0; k < 64; k++) begin
      logic [8:0] op = {3'b110, k[5:0]};
      run_vec(op, '0, '1, '1);
      run_vec(op, '1, '0, '0);
      run_vec(op, '1, '1, '1);
      run_vec(op, 36'h0000FF00F, 36'h123400000, 18'h0000F);
      for (int r = 0; r < 4; r++) begin
        seed = nxt_rand(seed);
        ac_in = seed;
        seed = nxt_rand(seed);
        run_vec(op, ac_in, seed, seed[H+5:6]);
      end
    end
  endtask

  task automatic t_pre_mod_zero;
    // R7: set and complement of masked bits that start at zero: zero test sees zeros
    run_vec({3'b110, 2'b11, 1'b1, 2'b01, 1'b0}, 36'h0, 36'h00000FFFF, '0);
    run_vec({3'b110, 2'b10, 1'b1, 2'b11, 1'b0}, 36'h0, 36'h00000FFFF, '0);
    run_vec({3'b110, 2'b01, 1'b0, 2'b11, 1'b1}, 36'h3FFFC0000, '0, 18'h3FFFF);
  endtask

  task automatic t_other_groups;
    for (int g = 0; g < 8; g++)
      if (g != 6) run_vec({g[2:0], 6'b111101}, '1, '1, '1);  // R1 ignored
  endtask

  task automatic t_back_to_back;
    // R9
    @(negedge clk);
    op_valid = 1'b1; opcode = {3'b110, 2'b11, 1'b0, 2'b10, 1'b0};
    ac_in = 36'h0; ea = 18'h00005; mem_in = '0;
    @(negedge clk);
    chk("R9 first valid", {35'd0, res_valid}, 36'd1);
    chk("R9 first ac_out", ac_out, 36'h000000005);
    opcode = {3'b110, 2'b01, 1'b1, 2'b01, 1'b1};
    ac_in = 36'hFFFFFFFFF; mem_in = 36'h00000000F;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 second valid", {35'd0, res_valid}, 36'd1);
    chk("R9 second ac_out", ac_out, 36'hFFFC3FFFF);
    chk("R9 second skip", {35'd0, skip}, 36'd0);
    @(negedge clk);
    chk("R9 idle valid", {35'd0, res_valid}, 36'd0);
  endtask

  initial begin
    t_reset;
    t_all_combos;
    t_pre_mod_zero;
    t_other_groups;
    t_back_to_back;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule